// File: doc/BRIEF.md
# Cross-Clock Receive Status Synchronizer

This block is the receive-status path of a UART whose serial engine runs on its own clock, unrelated to the host bus clock. When the serial engine finishes a byte, it raises `byte_done` for one serial clock cycle and presents the byte on `byte_data`. The block holds that byte and flips a level flag in the serial domain. A two-flop synchronizer carries the flag into the bus domain, where it becomes the ready bit of a readable status word.

On the bus side, a read of the data register returns the held byte. It also flips an acknowledge level, which a second two-flop synchronizer carries back to the serial domain to free the holding register. The ready bit always comes through the two bus-clock flops, so it lags the real event by two bus clocks. A read that lands near the event sees a clean 0 or a clean 1.

Every bus read result is captured in a register on the bus clock and held until the next read, so the bus sees a constant value for the whole cycle.

Top module: `ustat_rx_status`

## Requirements
- R1: After both resets, `rd_data` is 0 and a status read returns ready = 0.
- R2: A status read (`rd_sel` = 0) returns the ready flag in bit 0 and zero in every other bit.
- R3: Let the serial clock edge that samples `byte_done` high be the event. A status read captured on the first or second bus clock edge after the event returns ready = 0. A status read captured on the third or any later edge returns 1.
- R4: A data read (`rd_sel` = 1) while ready returns the held byte. The next status read returns ready = 0.
- R5: A data read while ready is 0 does not change the ready state; a following status read still returns 0.
- R6: A `byte_done` that arrives while the previous byte has not yet been acknowledged back in the serial domain is dropped, and the held byte is kept.
- R7: Once the acknowledge has crossed back, which takes two serial clock edges after the data read, a new byte is accepted and becomes readable.
- R8: `rd_data` changes only on a bus clock edge at which `rd_en` is high, and holds its value otherwise.
- R9: Each completion flips a level, not a pulse, so a run of bytes that are each consumed before the next one arrives is all delivered, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ser_clk | input | 1 | Serial engine clock |
| ser_rst | input | 1 | Synchronous active-high reset, serial domain |
| byte_done | input | 1 | One-cycle pulse: a byte has completed |
| byte_data | input | DW | Byte value, valid while byte_done is high |
| bus_clk | input | 1 | Host bus clock |
| bus_rst | input | 1 | Synchronous active-high reset, bus domain |
| rd_en | input | 1 | Bus read strobe, one bus cycle per read |
| rd_sel | input | 1 | Register select: 0 status, 1 data |
| rd_data | output | DW | Registered read result |

## Verification
The hardest condition to reach from the ports is the exact boundary of the two-clock lag. The serial and bus clocks are unrelated, so the bus edge on which ready first appears is not fixed in advance. The bench counts bus edges and records that count at the serial edge that accepts `byte_done`. It then issues a status read on every following bus cycle and predicts each result from the edge index. The dropped-byte case is reached by sending a second completion one serial cycle after the first, before any read can acknowledge the first.

// File: rtl/ustat_pkg.sv
package ustat_pkg;

    typedef enum logic {
        REG_STATUS = 1'b0,
        REG_DATA   = 1'b1
    } ustat_reg_e;

    localparam int READY_BIT = 0;

endpackage

// File: rtl/ustat_sync.sv
module ustat_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] stage_d;
    logic [STAGES-1:0] stage_q;

    always_comb begin
        stage_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) stage_q <= {STAGES{RESET_VAL}};
        else     stage_q <= stage_d;
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/ustat_ser_side.sv
module ustat_ser_side #(
    parameter int DW = 8
) (
    input  logic          ser_clk,
    input  logic          ser_rst,
    input  logic          byte_done,
    input  logic [DW-1:0] byte_data,
    input  logic          ack_tgl_s,
    output logic          done_tgl,
    output logic [DW-1:0] hold_data
);
    typedef struct packed {
        logic          done_tgl;
        logic [DW-1:0] hold;
    } ser_st_t;

    ser_st_t st_d, st_q;
    logic    pending;

    // A byte is outstanding while the bus has not echoed the level back.
    assign pending = st_q.done_tgl ^ ack_tgl_s;

    always_comb begin
        st_d = st_q;
        if (byte_done && !pending) begin
            st_d.done_tgl = ~st_q.done_tgl;
            st_d.hold     = byte_data;
        end
    end

    always_ff @(posedge ser_clk) begin
        if (ser_rst) st_q <= '0;
        else         st_q <= st_d;
    end

    assign done_tgl  = st_q.done_tgl;
    assign hold_data = st_q.hold;

    // R6: a completion during a pending byte leaves the held byte alone
    assert_drop_keeps_hold_R6: assert property (@(posedge ser_clk) disable iff (ser_rst)
        (byte_done && pending) |=> $stable(hold_data));

    // R9: the completion level only moves on a completion
    assert_tgl_on_event_R9: assert property (@(posedge ser_clk) disable iff (ser_rst)
        !byte_done |=> $stable(done_tgl));

endmodule

// File: rtl/ustat_bus_side.sv
module ustat_bus_side
    import ustat_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          bus_clk,
    input  logic          bus_rst,
    input  logic          done_tgl_b,
    input  logic [DW-1:0] hold_data,
    input  logic          rd_en,
    input  logic          rd_sel,
    output logic [DW-1:0] rd_data,
    output logic          ack_tgl
);
    typedef struct packed {
        logic          ack_tgl;
        logic [DW-1:0] rd_data;
    } bus_st_t;

    bus_st_t       st_d, st_q;
    logic          ready;
    logic [DW-1:0] status_word;
    logic          data_rd;

    assign ready   = done_tgl_b ^ st_q.ack_tgl;
    assign data_rd = rd_en && (rd_sel == REG_DATA);

    always_comb begin
        status_word            = '0;
        status_word[READY_BIT] = ready;
    end

    always_comb begin
        st_d = st_q;
        if (rd_en) begin
            st_d.rd_data = (rd_sel == REG_DATA) ? hold_data : status_word;
        end
        if (data_rd && ready) begin
            st_d.ack_tgl = ~st_q.ack_tgl;
        end
    end

    always_ff @(posedge bus_clk) begin
        if (bus_rst) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rd_data = st_q.rd_data;
    assign ack_tgl = st_q.ack_tgl;

    // R8: read result holds between reads
    assert_rd_hold_R8: assert property (@(posedge bus_clk) disable iff (bus_rst)
        !rd_en |=> $stable(rd_data));

    // R5: acknowledge moves only on a data read while ready
    assert_ack_only_when_ready_R5: assert property (@(posedge bus_clk) disable iff (bus_rst)
        !(data_rd && ready) |=> $stable(ack_tgl));

    // R4: a consuming data read clears ready on the next cycle
    assert_ready_clears_R4: assert property (@(posedge bus_clk) disable iff (bus_rst)
        (data_rd && ready) |=> !ready);

endmodule

// File: rtl/ustat_rx_status.sv
module ustat_rx_status #(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          ser_clk,
    input  logic          ser_rst,
    input  logic          byte_done,
    input  logic [DW-1:0] byte_data,
    input  logic          bus_clk,
    input  logic          bus_rst,
    input  logic          rd_en,
    input  logic          rd_sel,
    output logic [DW-1:0] rd_data
);
    logic          done_tgl;
    logic          done_tgl_b;
    logic          ack_tgl;
    logic          ack_tgl_s;
    logic [DW-1:0] hold_data;

    ustat_ser_side #(.DW(DW)) u_ser (
        .ser_clk   (ser_clk),
        .ser_rst   (ser_rst),
        .byte_done (byte_done),
        .byte_data (byte_data),
        .ack_tgl_s (ack_tgl_s),
        .done_tgl  (done_tgl),
        .hold_data (hold_data)
    );

    ustat_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_done (
        .clk (bus_clk),
        .rst (bus_rst),
        .d   (done_tgl),
        .q   (done_tgl_b)
    );

    ustat_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_ack (
        .clk (ser_clk),
        .rst (ser_rst),
        .d   (ack_tgl),
        .q   (ack_tgl_s)
    );

    ustat_bus_side #(.DW(DW)) u_bus (
        .bus_clk    (bus_clk),
        .bus_rst    (bus_rst),
        .done_tgl_b (done_tgl_b),
        .hold_data  (hold_data),
        .rd_en      (rd_en),
        .rd_sel     (rd_sel),
        .rd_data    (rd_data),
        .ack_tgl    (ack_tgl)
    );

endmodule

// File: tb/ustat_rx_status_bench.sv
`timescale 1ns/100ps
module ustat_rx_status_bench;
    localparam int DW = 8;

    logic          ser_clk = 1'b0;
    logic          bus_clk = 1'b0;
    logic          ser_rst = 1'b1;
    logic          bus_rst = 1'b1;
    logic          byte_done = 1'b0;
    logic [DW-1:0] byte_data = '0;
    logic          rd_en = 1'b0;
    logic          rd_sel = 1'b0;
    logic [DW-1:0] rd_data;

    int checks = 0;
    int fails  = 0;
    int bus_cyc = 0;
    int ev_cyc  = 0;

    always #4   bus_clk = ~bus_clk;
    always #6.5 ser_clk = ~ser_clk;

    always @(posedge bus_clk) bus_cyc <= bus_cyc + 1;
    always @(posedge ser_clk) if (byte_done) ev_cyc = bus_cyc;

    ustat_rx_status #(.DW(DW)) u_ustat_rx_status (
        .ser_clk   (ser_clk),
        .ser_rst   (ser_rst),
        .byte_done (byte_done),
        .byte_data (byte_data),
        .bus_clk   (bus_clk),
        .bus_rst   (bus_rst),
        .rd_en     (rd_en),
        .rd_sel    (rd_sel),
        .rd_data   (rd_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_read(input logic sel, output logic [DW-1:0] val, output int idx);
        @(negedge bus_clk);
        rd_en  = 1'b1;
        rd_sel = sel;
        @(posedge bus_clk);
        #1;
        idx   = bus_cyc;
        val   = rd_data;
        rd_en = 1'b0;
    endtask

    task automatic send_byte(input logic [DW-1:0] v);
        @(negedge ser_clk);
        byte_done = 1'b1;
        byte_data = v;
        @(negedge ser_clk);
        byte_done = 1'b0;
    endtask

    task automatic wait_bus(input int n);
        repeat (n) @(posedge bus_clk);
    endtask

    task automatic wait_ser(input int n);
        repeat (n) @(posedge ser_clk);
    endtask

    task automatic t_reset;
        logic [DW-1:0] v; int idx;
        chk("R1 rd_data after reset", rd_data, 0);
        bus_read(1'b0, v, idx);
        chk("R1 ready after reset", v, 0);
    endtask

    task automatic t_lag;
        logic [DW-1:0] v; int idx;
        send_byte(8'hA5);
        for (int i = 0; i < 6; i++) begin
            bus_read(1'b0, v, idx);
            chk("R3 ready lag", v, (idx >= ev_cyc + 3) ? 1 : 0);
        end
        chk("R2 status upper bits zero", v, 8'h01);
        bus_read(1'b1, v, idx);
        chk("R4 data read value", v, 8'hA5);
        bus_read(1'b0, v, idx);
        chk("R4 ready cleared", v, 0);
        wait_ser(4);
    endtask

    task automatic t_not_ready;
        logic [DW-1:0] v; int idx;
        bus_read(1'b1, v, idx);
        bus_read(1'b0, v, idx);
        chk("R5 ready after idle data read", v, 0);
        wait_ser(4);
        bus_read(1'b0, v, idx);
        chk("R5 ready still clear", v, 0);
    endtask

    task automatic t_hold;
        logic [DW-1:0] v; int idx;
        bus_read(1'b0, v, idx);
        chk("R8 status before byte", v, 0);
        send_byte(8'h5C);
        wait_bus(6);
        @(negedge bus_clk);
        chk("R8 rd_data held without read", rd_data, 0);
        bus_read(1'b1, v, idx);
        chk("R8 data read after hold", v, 8'h5C);
        wait_ser(4);
    endtask

    task automatic t_drop;
        logic [DW-1:0] v; int idx;
        send_byte(8'h11);
        send_byte(8'h22);
        wait_bus(4);
        bus_read(1'b1, v, idx);
        chk("R6 first byte kept", v, 8'h11);
        wait_ser(5);
        bus_read(1'b0, v, idx);
        chk("R6 second byte dropped", v, 0);
        send_byte(8'h33);
        wait_bus(4);
        bus_read(1'b0, v, idx);
        chk("R7 ready after ack returned", v, 1);
        bus_read(1'b1, v, idx);
        chk("R7 new byte accepted", v, 8'h33);
        wait_ser(4);
    endtask

    task automatic t_stream;
        logic [DW-1:0] v; int idx;
        for (int i = 0; i < 4; i++) begin
            send_byte(DW'(8'h40 + i));
            wait_bus(4);
            bus_read(1'b0, v, idx);
            chk("R9 ready per byte", v, 1);
            bus_read(1'b1, v, idx);
            chk("R9 byte order", v, 32'h40 + i);
            wait_ser(4);
        end
    endtask

    initial begin
        repeat (4) @(posedge ser_clk);
        repeat (4) @(posedge bus_clk);
        @(negedge ser_clk) ser_rst = 1'b0;
        @(negedge bus_clk) bus_rst = 1'b0;
        wait_bus(2);
        t_reset();
        t_lag();
        t_not_ready();
        t_hold();
        t_drop();
        t_stream();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #800000;
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule